// File: doc/BRIEF.md
# Data Link Receive Interrupt Controller

This block collects interrupt events from the receive side of a framer's data link channel and presents them to a microprocessor as one level-sensitive interrupt request. The data link receiver sends it single-cycle pulses for three events: a message has started, a message has ended, and an abort sequence has been detected. Each pulse sets a sticky status bit.

Each status bit is masked by its own enable bit and then by a block-wide enable. The interrupt request is the OR of the surviving terms, and it is held in a small state machine so that the output is a registered level.

Software reaches four byte-wide registers over a simple synchronous bus. One strobe cycle performs one access, and read data is returned in the following cycle. A mode bit in the control register chooses how status bits are cleared. In clear-on-read mode, reading the status register clears every bit it returned as 1. In write-one-to-clear mode, software writes 1 to the bits it wants to clear. The mode can be changed at run time.

Top module: `dl_irq_ctrl`

## Requirements
- R1: After reset, all four registers read 0x00, `irq` is 0 and `bus_rdata` is 0x00.
- R2: The event enable register at address 0x07 stores bit 6 (abort), bit 5 (message start) and bit 3 (message end), where 1 enables. All its other bits read 0 and ignore writes.
- R3: The block enable register at address 0x00 stores only bit 3. The control register at address 0x01 stores only bit 0, where 1 selects clear-on-read. All other bits of these two registers read 0.
- R4: The status register sits at address 0x06. A pulse on `ev_start` sets bit 5, a pulse on `ev_end` sets bit 3 and a pulse on `ev_abort` sets bit 6. Each bit is set at the clock edge that samples the pulse and stays set until it is cleared. Unused bits read 0.
- R5: In clear-on-read mode, a status read returns the current bits and clears exactly the bits it returned as 1. Writes to the status register have no effect in this mode.
- R6: In write-one-to-clear mode, writing 1 to a status bit clears it and writing 0 leaves it unchanged. Reading the status register does not clear anything in this mode.
- R7: If an event arrives in the same cycle as a clear of its status bit, the event wins and the bit stays set. This holds in both clear modes.
- R8: `irq` changes one clock edge after any change of the registered term: block enable AND the OR over sources of (status AND enable). A source whose enable bit is 0 does not raise `irq`.
- R9: While block enable bit 3 is 0, `irq` stays 0 whatever the status and event enable bits hold.
- R10: `bus_rdata` is loaded at the edge that samples a read strobe and holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_start | input | 1 | Pulse: a data link message has started |
| ev_end | input | 1 | Pulse: a data link message has ended |
| ev_abort | input | 1 | Pulse: an abort sequence has been received |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read, qualified by bus_sel |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Level interrupt request to the microprocessor |

## Verification
An event pulse appears in the status register one edge after it is sampled, and `irq` follows one edge after that. A clear, or a change to an enable, likewise takes effect on `irq` one edge after the register changes. Read data is valid one edge after the read strobe.

The bench drives inputs on falling edges. A monitor pops the expected read value from a queue just after the rising edge that samples each read. Interrupt checks are placed on the falling edge of the cycle in which the two-edge latency has elapsed. One extra check is made one cycle early to confirm that `irq` has not yet risen.

// File: rtl/dl_irq_pkg.sv
package dl_irq_pkg;

    localparam int DEF_ADDR_W = 8;
    localparam int DEF_DATA_W = 8;
    localparam int NSRC       = 3;

    // Register addresses
    localparam int OFS_BLOCK  = 8'h00;
    localparam int OFS_CTRL   = 8'h01;
    localparam int OFS_STATUS = 8'h06;
    localparam int OFS_ENABLE = 8'h07;

    // Single-bit fields
    localparam int POS_BLOCK_EN = 3;
    localparam int POS_CLR_RD   = 0;

    // Source index -> bit position in the status and enable registers
    function automatic int src_pos(input int idx);
        case (idx)
            0:       return 5;   // message start
            1:       return 3;   // message end
            default: return 6;   // abort sequence
        endcase
    endfunction

    typedef enum logic [1:0] {
        BUS_IDLE  = 2'd0,
        BUS_READ  = 2'd1,
        BUS_WRITE = 2'd2
    } bus_op_e;

    typedef enum logic {
        IRQ_QUIET    = 1'b0,
        IRQ_ASSERTED = 1'b1
    } irq_state_e;

endpackage

// File: rtl/dl_irq_regs.sv
module dl_irq_regs
    import dl_irq_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int DATA_W = DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_op_e           op,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NSRC-1:0]   status_q,
    output logic [NSRC-1:0]   en_q,
    output logic              blk_en_q,
    output logic              clr_rd_q,
    output logic              sts_rd,
    output logic              sts_wr,
    output logic [DATA_W-1:0] rdata
);

    localparam logic [ADDR_W-1:0] A_BLOCK  = ADDR_W'(OFS_BLOCK);
    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
    localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(OFS_ENABLE);

    logic              hit_block, hit_ctrl, hit_status, hit_enable;
    logic [DATA_W-1:0] sts_word, en_word, blk_word, ctl_word, rd_mux;
    logic [DATA_W-1:0] rdata_q;

    assign hit_block  = (addr == A_BLOCK);
    assign hit_ctrl   = (addr == A_CTRL);
    assign hit_status = (addr == A_STATUS);
    assign hit_enable = (addr == A_ENABLE);

    assign sts_rd = (op == BUS_READ)  && hit_status;
    assign sts_wr = (op == BUS_WRITE) && hit_status;

    // Per-source enable flops
    for (genvar g = 0; g < NSRC; g++) begin : g_en
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                en_q[g] <= 1'b0;
            end else if (op == BUS_WRITE && hit_enable) begin
                en_q[g] <= wdata[src_pos(g)];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            blk_en_q <= 1'b0;
            clr_rd_q <= 1'b0;
        end else if (op == BUS_WRITE) begin
            if (hit_block) blk_en_q <= wdata[POS_BLOCK_EN];
            if (hit_ctrl)  clr_rd_q <= wdata[POS_CLR_RD];
        end
    end

    // Pack the stored bits into register words; unused bits read 0
    always_comb begin
        sts_word = '0;
        en_word  = '0;
        blk_word = '0;
        ctl_word = '0;
        for (int i = 0; i < NSRC; i++) begin
            sts_word[src_pos(i)] = status_q[i];
            en_word[src_pos(i)]  = en_q[i];
        end
        blk_word[POS_BLOCK_EN] = blk_en_q;
        ctl_word[POS_CLR_RD]   = clr_rd_q;
    end

    always_comb begin
        rd_mux = '0;
        if (hit_block)  rd_mux = blk_word;
        if (hit_ctrl)   rd_mux = ctl_word;
        if (hit_status) rd_mux = sts_word;
        if (hit_enable) rd_mux = en_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (op == BUS_READ) begin
            rdata_q <= rd_mux;
        end
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/dl_irq_status.sv
module dl_irq_status
    import dl_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] ev,
    input  logic [NSRC-1:0] clr,
    output logic [NSRC-1:0] status_q
);

    // Sticky bits: an event in the same cycle as a clear keeps the bit set
    for (genvar g = 0; g < NSRC; g++) begin : g_sticky
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                status_q[g] <= 1'b0;
            end else if (ev[g]) begin
                status_q[g] <= 1'b1;
            end else if (clr[g]) begin
                status_q[g] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/dl_irq_fsm.sv
module dl_irq_fsm
    import dl_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pending,
    output logic irq
);

    irq_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_QUIET;
        else        state_q <= state_d;
    end

    // Transitions: RAISE (quiet -> asserted), DROP (asserted -> quiet)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET:    if (pending)  state_d = IRQ_ASSERTED;
            IRQ_ASSERTED: if (!pending) state_d = IRQ_QUIET;
        endcase
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            IRQ_QUIET:    irq = 1'b0;
            IRQ_ASSERTED: irq = 1'b1;
        endcase
    end

endmodule

// File: rtl/dl_irq_ctrl.sv
module dl_irq_ctrl
    import dl_irq_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int DATA_W = DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_start,
    input  logic              ev_end,
    input  logic              ev_abort,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    bus_op_e         op;
    logic [NSRC-1:0] ev_vec, clr_vec, status_q, en_q;
    logic            blk_en_q, clr_rd_q, sts_rd, sts_wr, pending;

    always_comb begin
        op = BUS_IDLE;
        if (bus_sel) op = bus_wr ? BUS_WRITE : BUS_READ;
    end

    assign ev_vec = {ev_abort, ev_end, ev_start};

    dl_irq_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .status_q (status_q),
        .en_q     (en_q),
        .blk_en_q (blk_en_q),
        .clr_rd_q (clr_rd_q),
        .sts_rd   (sts_rd),
        .sts_wr   (sts_wr),
        .rdata    (bus_rdata)
    );

    // Clear requests per source, chosen by the clear mode
    always_comb begin
        for (int i = 0; i < NSRC; i++) begin
            if (clr_rd_q) clr_vec[i] = sts_rd && status_q[i];
            else          clr_vec[i] = sts_wr && bus_wdata[src_pos(i)];
        end
    end

    dl_irq_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev       (ev_vec),
        .clr      (clr_vec),
        .status_q (status_q)
    );

    assign pending = blk_en_q && |(status_q & en_q);

    dl_irq_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .pending (pending),
        .irq     (irq)
    );

endmodule

// File: rtl/dl_irq_checker.sv
module dl_irq_checker
    import dl_irq_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic [NSRC-1:0] ev,
    input logic [NSRC-1:0] status,
    input logic [NSRC-1:0] en,
    input logic            blk_en,
    input logic            clr_rd,
    input logic            sts_rd,
    input logic            sts_wr,
    input logic            irq
);

    a_r4_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (ev != '0) |=> ((status & $past(ev)) == $past(ev)));

    a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!sts_rd && !sts_wr) |=> ((status & $past(status)) == $past(status)));

    a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_rd && sts_rd && ev == '0) |=> (status == '0));

    a_r6_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_rd && sts_rd) |=> ((status & $past(status)) == $past(status)));

    a_r8_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
        (status != '0 || irq) |=> (irq == $past(blk_en && |(status & en))));

    a_r9_block_mask: assert property (@(posedge clk) disable iff (!rst_n)
        !blk_en |=> !irq);

endmodule

bind dl_irq_ctrl dl_irq_checker u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .ev     (ev_vec),
    .status (status_q),
    .en     (en_q),
    .blk_en (blk_en_q),
    .clr_rd (clr_rd_q),
    .sts_rd (sts_rd),
    .sts_wr (sts_wr),
    .irq    (irq)
);

// File: tb/dl_irq_ctrl_bench.sv
module dl_irq_ctrl_bench;

    localparam logic [7:0] A_BLK = 8'h00, A_CTL = 8'h01, A_STS = 8'h06, A_ENA = 8'h07;
    localparam logic [2:0] E_ST = 3'b001, E_EN = 3'b010, E_AB = 3'b100;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ev_start = 1'b0, ev_end = 1'b0, ev_abort = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0] bus_addr = '0, bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq;

    always #4 clk = ~clk;

    dl_irq_ctrl u_dl_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_end(ev_end),
        .ev_abort(ev_abort), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    typedef struct { logic [7:0] exp; string tag; } exp_t;
    exp_t sb_q[$];

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // Driver: one bus cycle with optional concurrent events
    task automatic cyc(input logic s, input logic w, input logic [7:0] a,
                       input logic [7:0] d, input logic [2:0] ev,
                       input logic [7:0] exp, input string tag);
        bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d;
        {ev_abort, ev_end, ev_start} = ev;
        if (s && !w) sb_q.push_back('{exp, tag});
        @(negedge clk);
        bus_sel = 0; bus_wr = 0; {ev_abort, ev_end, ev_start} = 3'b000;
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
        cyc(1, 0, a, 8'h00, 3'b000, exp, tag);
    endtask
    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        cyc(1, 1, a, d, 3'b000, 8'h00, "");
    endtask
    task automatic pulse(input logic [2:0] ev);
        cyc(0, 0, 8'h00, 8'h00, ev, 8'h00, "");
    endtask
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Monitor: compare read data just after the sampling edge
    initial begin
        forever begin
            @(posedge clk);
            if (rst_n && bus_sel && !bus_wr) begin
                exp_t e;
                #1;
                if (sb_q.size() == 0) begin
                    n_chk++; n_err++;
                    $display("FAIL scoreboard: actual=%02h expected=none", bus_rdata);
                end else begin
                    e = sb_q.pop_front();
                    check(bus_rdata, e.exp, e.tag);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        idle(3);
        // R1 reset state
        check({7'b0, irq}, 8'h00, "R1 irq");
        check(bus_rdata, 8'h00, "R1 rdata");
        rst_n = 1'b1;
        idle(1);
        rd(A_BLK, 8'h00, "R1 block");
        rd(A_CTL, 8'h00, "R1 ctrl");
        rd(A_STS, 8'h00, "R1 status");
        rd(A_ENA, 8'h00, "R1 enable");

        // R2, R3 register fields
        wr(A_ENA, 8'hFF); rd(A_ENA, 8'h68, "R2 enable bits");
        wr(A_BLK, 8'hFF); rd(A_BLK, 8'h08, "R3 block bit");
        wr(A_CTL, 8'hFF); rd(A_CTL, 8'h01, "R3 ctrl bit");
        wr(A_CTL, 8'h00);

        // R4, R8, R6: write-one-to-clear mode
        pulse(E_ST);
        check({7'b0, irq}, 8'h00, "R8 irq not yet");
        idle(1);
        check({7'b0, irq}, 8'h01, "R8 irq raised");
        rd(A_STS, 8'h20, "R4 start bit");
        rd(A_STS, 8'h20, "R6 read keeps");
        wr(A_STS, 8'h08); rd(A_STS, 8'h20, "R6 zero leaves");
        wr(A_STS, 8'h20);
        check({7'b0, irq}, 8'h01, "R8 irq one edge late");
        idle(1);
        check({7'b0, irq}, 8'h00, "R8 irq dropped");
        rd(A_STS, 8'h00, "R6 one clears");

        // R9 block mask, R8 per-source enable
        wr(A_BLK, 8'h00);
        pulse(E_EN);
        idle(2);
        check({7'b0, irq}, 8'h00, "R9 masked");
        rd(A_STS, 8'h08, "R4 end bit");
        wr(A_BLK, 8'h08);
        idle(1);
        check({7'b0, irq}, 8'h01, "R9 unmasked");
        wr(A_ENA, 8'h60);
        idle(1);
        check({7'b0, irq}, 8'h00, "R8 source disabled");
        wr(A_STS, 8'h08);
        wr(A_ENA, 8'h68);

        // R7 event beats write clear
        cyc(1, 1, A_STS, 8'h40, E_AB, 8'h00, "");
        rd(A_STS, 8'h40, "R7 event wins w1c");
        check({7'b0, irq}, 8'h01, "R8 abort irq");
        wr(A_STS, 8'h40);
        idle(1);
        check({7'b0, irq}, 8'h00, "R8 abort cleared");

        // R5 clear-on-read mode, R10 hold
        wr(A_CTL, 8'h01);
        pulse(E_ST | E_EN);
        rd(A_STS, 8'h28, "R5 read returns");
        idle(3);
        check(bus_rdata, 8'h28, "R10 rdata held");
        rd(A_STS, 8'h00, "R5 read cleared");
        pulse(E_AB);
        wr(A_STS, 8'h40);
        rd(A_STS, 8'h40, "R5 write ignored");
        rd(A_STS, 8'h00, "R5 cleared again");

        // R7 event beats read clear
        pulse(E_ST);
        cyc(1, 0, A_STS, 8'h00, E_EN, 8'h20, "R7 read snapshot");
        rd(A_STS, 8'h08, "R7 event wins cor");
        idle(2);
        check({7'b0, irq}, 8'h00, "R8 irq after read clear");

        idle(2);
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule